// File: doc/BRIEF.md
# I2C Target with Event Stall

This block is the target side of an I2C bus. It watches SCL and SDA through a resynchroniser and compares each address byte with a 7-bit own address that software programs. It reports what happens on the bus as two sticky events. A command event covers an addressed start or a later stop. A data event covers a byte that has been received or transmitted. An interrupt is raised while any event is pending and unmasked.

While an event is pending the block can hold SCL low, which keeps the master waiting until software has answered. A single command word carries the whole answer. It clears the events, it sets whether the next received byte is acknowledged, and on reads it supplies the next byte to transmit. SCL is let go on the cycle after that word is written. Addresses that do not match leave the block silent until the next start condition.

Top module: `i2c_target_stall`

## Requirements
- R1: After reset, scl_oe, sda_oe and irq are 0, and the event, status and receive-byte outputs are all zero.
- R2: The own-address register keeps the address in bits 7:1. An address byte whose upper seven bits match it is ACKed. After the ACK clock, event bit 0 is set and status bit 2 equals the received R/W bit, where 1 means the master reads. Status bit 5 is 0.
- R3: An address that does not match, or any address while the own-address register is zero, gets no ACK and no event. Every later byte and any stop are then ignored until the next start.
- R4: A byte written by the master appears on the receive-byte output, and event bit 1 is set after its ACK clock. The byte is ACKed only if command bit 3 was 1 in the most recent command write.
- R5: When command bit 0 is 1, the block drives scl_oe from the end of the ACK clock that follows an addressed start or any byte. It keeps scl_oe high until a command write with bit 6 set, and releases it on the next cycle. scl_oe is never 1 while no event is pending.
- R6: A command write with bit 6 set clears both event bits. irq is 1 when any event bit is set and command bit 4 (mask) is 0.
- R7: On a read, the block sends the byte in bits 15:8 of the command word, MSB first. Status bit 3 is 1 when the master ACKed the byte.
- R8: After the master NACKs a transmitted byte, status bit 3 is 0. The block then stops driving SDA until the next start, whatever byte later commands carry.
- R9: A stop after an addressed start sets event bit 0 and status bit 5. A stop never causes SCL to be held.
- R10: When command bit 0 is 0, SCL is never held. A read then sends bits 15:8 of the most recent command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| own_we | input | 1 | Write strobe for the own-address register |
| own_wdata | input | 8 | Own address in bits 7:1; zero disables matching |
| cmd_we | input | 1 | Write strobe for the command word |
| cmd_wdata | input | 16 | Command: 15:8 transmit byte, 6 clear, 4 mask, 3 ACK enable, 0 stall enable |
| scl_i | input | 1 | Sensed SCL level |
| sda_i | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| irq | output | 1 | Pending unmasked event |
| sts_rd | output | 8 | Status: 5 stop seen, 3 master ACK, 2 direction |
| evt_rd | output | 8 | Events: 0 command, 1 data |
| rxd_rd | output | 8 | Last byte received from the master |

## Verification
Most faults in the state register or the bit counter show up on SDA within one byte. The symptom is an ACK in the wrong clock, or a missing ACK, or a transmitted bit at the wrong position, and the master model sees it in that same byte. A fault in the hold flag shows up at scl_oe one cycle after a clear, or as scl_oe set while the event outputs read zero. A per-clock comparison catches that second case at once. Faults in how events are raised show up on evt_rd and irq three clocks after the SCL fall that ends the ACK clock.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int BYTE_W   = 8;
  localparam int CMD_W    = 16;
  localparam int ADDR_W   = 7;
  localparam int CNT_W    = 4;

  localparam int CMD_CLEAR = 6;
  localparam int CMD_MASK  = 4;
  localparam int CMD_ACKEN = 3;
  localparam int CMD_STALL = 0;
  localparam int CMD_TXLSB = 8;

  localparam int STS_STOP = 5;
  localparam int STS_MACK = 3;
  localparam int STS_DIR  = 2;

  typedef enum logic [2:0] {
    LS_IDLE, LS_ADDR, LS_AACK, LS_RECV, LS_RACKOUT, LS_SEND, LS_SACKIN, LS_PARK
  } link_st_e;
endpackage

// File: rtl/i2ct_bus_sync.sv
module i2ct_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_ch, sda_ch;
  logic scl_prev, sda_prev;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ch[i] <= 1'b1;
          sda_ch[i] <= 1'b1;
        end else begin
          scl_ch[i] <= scl_i;
          sda_ch[i] <= sda_i;
        end
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          scl_ch[i] <= 1'b1;
          sda_ch[i] <= 1'b1;
        end else begin
          scl_ch[i] <= scl_ch[i-1];
          sda_ch[i] <= sda_ch[i-1];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_ch[STAGES-1];
      sda_prev <= sda_ch[STAGES-1];
    end
  end

  assign scl_s     = scl_ch[STAGES-1];
  assign sda_s     = sda_ch[STAGES-1];
  assign scl_rise  = scl_s & ~scl_prev;
  assign scl_fall  = ~scl_s & scl_prev;
  assign start_det = scl_s & scl_prev & ~sda_s & sda_prev;
  assign stop_det  = scl_s & scl_prev & sda_s & ~sda_prev;
endmodule

// File: rtl/i2ct_link.sv
module i2ct_link
  import i2ct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              ack_en,
  input  logic              hold,
  input  logic              release_now,
  input  logic [BYTE_W-1:0] tx_next,
  output logic              sda_oe,
  output logic              ev_cmd,
  output logic              ev_data,
  output logic              ev_stop,
  output logic [BYTE_W-1:0] status,
  output logic [BYTE_W-1:0] rx_byte
);
  link_st_e          st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d, rx_q, rx_d;
  logic              sda_q, sda_d, ldp_q, ldp_d;
  logic              dir_q, dir_d, mack_q, mack_d, stop_q, stop_d;
  logic              match_en;

  assign match_en = (own_addr != '0);

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sh_d = sh_q; rx_d = rx_q;
    sda_d = sda_q; ldp_d = ldp_q; dir_d = dir_q; mack_d = mack_q; stop_d = stop_q;
    ev_cmd = 1'b0; ev_data = 1'b0; ev_stop = 1'b0;
    if (start_det) begin
      st_d = LS_ADDR; cnt_d = '0; sda_d = 1'b0; stop_d = 1'b0; ldp_d = 1'b0;
    end else if (stop_det) begin
      if (st_q != LS_IDLE) begin
        ev_cmd = 1'b1; ev_stop = 1'b1; stop_d = 1'b1;
      end
      st_d = LS_IDLE; sda_d = 1'b0; ldp_d = 1'b0;
    end else begin
      unique case (st_q)
        LS_ADDR, LS_RECV: begin
          if (scl_rise) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_W'(BYTE_W)) begin
            if (st_q == LS_ADDR) begin
              if (match_en && sh_q[BYTE_W-1:1] == own_addr) begin
                st_d = LS_AACK; sda_d = 1'b1; dir_d = sh_q[0]; mack_d = 1'b0;
              end else begin
                st_d = LS_IDLE;
              end
            end else begin
              rx_d = sh_q; sda_d = ack_en; st_d = LS_RACKOUT;
            end
          end
        end
        LS_AACK: begin
          if (scl_fall) begin
            sda_d = 1'b0; ev_cmd = 1'b1; cnt_d = '0;
            if (dir_q) begin
              st_d = LS_SEND; ldp_d = 1'b1;
            end else begin
              st_d = LS_RECV;
            end
          end
        end
        LS_RACKOUT: begin
          if (scl_fall) begin
            sda_d = 1'b0; ev_data = 1'b1; cnt_d = '0; st_d = LS_RECV;
          end
        end
        LS_SEND: begin
          if (ldp_q) begin
            if (!hold || release_now) begin
              sh_d = tx_next; sda_d = ~tx_next[BYTE_W-1]; cnt_d = '0; ldp_d = 1'b0;
            end
          end else if (scl_fall) begin
            if (cnt_q == CNT_W'(BYTE_W - 1)) begin
              sda_d = 1'b0; st_d = LS_SACKIN;
            end else begin
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              sda_d = ~sh_q[BYTE_W-2];
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        LS_SACKIN: begin
          if (scl_rise) begin
            mack_d = ~sda_s;
          end else if (scl_fall) begin
            ev_data = 1'b1;
            if (mack_q) begin
              st_d = LS_SEND; ldp_d = 1'b1;
            end else begin
              st_d = LS_PARK;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= LS_IDLE; cnt_q <= '0; sh_q <= '0; rx_q <= '0;
      sda_q <= 1'b0; ldp_q <= 1'b0; dir_q <= 1'b0; mack_q <= 1'b0; stop_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sh_q <= sh_d; rx_q <= rx_d;
      sda_q <= sda_d; ldp_q <= ldp_d; dir_q <= dir_d; mack_q <= mack_d; stop_q <= stop_d;
    end
  end

  assign sda_oe  = sda_q;
  assign rx_byte = rx_q;
  always_comb begin
    status           = '0;
    status[STS_STOP] = stop_q;
    status[STS_MACK] = mack_q;
    status[STS_DIR]  = dir_q;
  end

  // R3: an unaddressed target never pulls SDA
  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LS_IDLE) |-> !sda_q);
  // R7: SDA is only taken low while the synchronised SCL was low
  assert_sda_rise_scl_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_q) |-> !$past(scl_s));
  // R8: after a master NACK the target stays off SDA
  assert_park_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LS_PARK) |-> !sda_q);
endmodule

// File: rtl/i2ct_evt_ctrl.sv
module i2ct_evt_ctrl
  import i2ct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              own_we,
  input  logic [BYTE_W-1:0] own_wdata,
  input  logic              cmd_we,
  input  logic [CMD_W-1:0]  cmd_wdata,
  input  logic              ev_cmd,
  input  logic              ev_data,
  input  logic              ev_stop,
  output logic [ADDR_W-1:0] own_addr,
  output logic              ack_en,
  output logic              hold,
  output logic              release_now,
  output logic [BYTE_W-1:0] tx_next,
  output logic [BYTE_W-1:0] events,
  output logic              irq
);
  logic [ADDR_W-1:0] own_q, own_d;
  logic              acken_q, acken_d, stall_q, stall_d, mask_q, mask_d;
  logic [BYTE_W-1:0] tx_q, tx_d;
  logic              evc_q, evc_d, evd_q, evd_d, hold_q, hold_d;
  logic              clr, raise_hold;
  logic              unused_bits;

  assign unused_bits = ^{own_wdata[0], cmd_wdata[7], cmd_wdata[5], cmd_wdata[2:1]};
  assign clr        = cmd_we & cmd_wdata[CMD_CLEAR];
  assign raise_hold = ((ev_cmd & ~ev_stop) | ev_data) & stall_q;

  always_comb begin
    own_d = own_q; acken_d = acken_q; stall_d = stall_q; mask_d = mask_q; tx_d = tx_q;
    if (own_we) own_d = own_wdata[BYTE_W-1:1];
    if (cmd_we) begin
      acken_d = cmd_wdata[CMD_ACKEN];
      stall_d = cmd_wdata[CMD_STALL];
      mask_d  = cmd_wdata[CMD_MASK];
      tx_d    = cmd_wdata[CMD_W-1:CMD_TXLSB];
    end
    evc_d = ev_cmd  | (evc_q & ~clr);
    evd_d = ev_data | (evd_q & ~clr);
    if (raise_hold)  hold_d = 1'b1;
    else if (clr)    hold_d = 1'b0;
    else             hold_d = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q <= '0; acken_q <= 1'b0; stall_q <= 1'b0; mask_q <= 1'b0; tx_q <= '0;
      evc_q <= 1'b0; evd_q <= 1'b0; hold_q <= 1'b0;
    end else begin
      own_q <= own_d; acken_q <= acken_d; stall_q <= stall_d; mask_q <= mask_d; tx_q <= tx_d;
      evc_q <= evc_d; evd_q <= evd_d; hold_q <= hold_d;
    end
  end

  assign own_addr    = own_q;
  assign ack_en      = acken_q;
  assign hold        = hold_q;
  assign release_now = clr;
  assign tx_next     = cmd_we ? cmd_wdata[CMD_W-1:CMD_TXLSB] : tx_q;
  assign events      = {{(BYTE_W-2){1'b0}}, evd_q, evc_q};
  assign irq         = (evc_q | evd_q) & ~mask_q;

  // R5: SCL is held only while an event is pending
  assert_hold_has_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> (evc_q | evd_q));
  // R5: a clear with no new event lets SCL go on the next cycle
  assert_release_after_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ev_cmd && !ev_data) |=> !hold_q);
  // R6: a clear with no new event empties the event register
  assert_clear_empties_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !ev_cmd && !ev_data) |=> (!evc_q && !evd_q));
  // R9: a stop does not start a hold
  assert_no_hold_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && !ev_data && !hold_q) |=> !hold_q);
endmodule

// File: rtl/i2c_target_stall.sv
module i2c_target_stall
  import i2ct_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        own_we,
  input  logic [7:0]  own_wdata,
  input  logic        cmd_we,
  input  logic [15:0] cmd_wdata,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        scl_oe,
  output logic        sda_oe,
  output logic        irq,
  output logic [7:0]  sts_rd,
  output logic [7:0]  evt_rd,
  output logic [7:0]  rxd_rd
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic [ADDR_W-1:0] own_addr;
  logic ack_en, hold, release_now, ev_cmd, ev_data, ev_stop;
  logic [BYTE_W-1:0] tx_next;

  i2ct_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2ct_link u_link (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .own_addr(own_addr), .ack_en(ack_en), .hold(hold), .release_now(release_now),
    .tx_next(tx_next), .sda_oe(sda_oe), .ev_cmd(ev_cmd), .ev_data(ev_data),
    .ev_stop(ev_stop), .status(sts_rd), .rx_byte(rxd_rd)
  );

  i2ct_evt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .own_we(own_we), .own_wdata(own_wdata),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .ev_cmd(ev_cmd), .ev_data(ev_data),
    .ev_stop(ev_stop), .own_addr(own_addr), .ack_en(ack_en), .hold(hold),
    .release_now(release_now), .tx_next(tx_next), .events(evt_rd), .irq(irq)
  );

  assign scl_oe = hold;
endmodule

// File: tb/tb_i2c_target_stall.sv
module tb_i2c_target_stall;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic own_we = 1'b0, cmd_we = 1'b0;
  logic [7:0] own_wdata = '0;
  logic [15:0] cmd_wdata = '0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe, irq;
  logic [7:0] sts_rd, evt_rd, rxd_rd;
  wire scl_bus = scl_m & ~scl_oe;
  wire sda_bus = sda_m & ~sda_oe;
  int checks = 0, failures = 0;
  localparam int Q = 4;

  always #2 clk = ~clk;

  i2c_target_stall dut (
    .clk(clk), .rst_n(rst_n), .own_we(own_we), .own_wdata(own_wdata),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq),
    .sts_rd(sts_rd), .evt_rd(evt_rd), .rxd_rd(rxd_rd)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R5 invariant compared on every clock: a held SCL implies a pending event
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (scl_oe && evt_rd == 8'h00) begin
        failures++;
        $display("FAIL R5 actual=scl_oe 1 with events %0h expected=no hold", evt_rd);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  task automatic sw_cmd(input logic [15:0] w);
    cmd_wdata = w; cmd_we = 1'b1; tick(1); cmd_we = 1'b0;
  endtask

  task automatic sw_own(input logic [7:0] w);
    own_wdata = w; own_we = 1'b1; tick(1); own_we = 1'b0;
  endtask

  task automatic mbit(input logic drv, output logic smp);
    sda_m = drv; tick(Q);
    scl_m = 1'b1;
    while (scl_bus !== 1'b1) tick(1);
    tick(Q); smp = sda_bus; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic mstart();
    sda_m = 1'b1; scl_m = 1'b1; tick(2*Q);
    sda_m = 1'b0; tick(2*Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic mstop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1;
    while (scl_bus !== 1'b1) tick(1);
    tick(2*Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic wbyte(input logic [7:0] d, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) mbit(d[i], s);
    mbit(1'b1, s);
    acked = ~s;
  endtask

  task automatic rbyte(input logic mack, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      mbit(1'b1, s);
      d[i] = s;
    end
    mbit(~mack, s);
  endtask

  initial begin
    logic a, s;
    logic [7:0] d;
    tick(4);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 scl_oe", scl_oe, 0);
    check("R1 sda_oe", sda_oe, 0);
    check("R1 irq", irq, 0);
    check("R1 events", evt_rd, 0);
    check("R1 status", sts_rd, 0);
    check("R1 rx", rxd_rd, 0);

    sw_own(8'hA0);
    sw_cmd(16'h0049);

    // write transaction with stall
    mstart();
    wbyte(8'hA0, a);
    check("R2 addr ack", a, 1);
    check("R2 cmd event", evt_rd, 8'h01);
    check("R2 status dir/stop", sts_rd & 8'h24, 0);
    check("R6 irq raised", irq, 1);
    check("R5 scl held", scl_oe, 1);
    tick(6);
    check("R5 still held", scl_oe, 1);
    sw_cmd(16'h0049);
    check("R5 released", scl_oe, 0);
    check("R6 cleared", evt_rd, 0);
    wbyte(8'h3C, a);
    check("R4 ack enabled", a, 1);
    check("R4 rx byte", rxd_rd, 8'h3C);
    check("R4 data event", evt_rd, 8'h02);
    check("R5 held after byte", scl_oe, 1);
    sw_cmd(16'h0041);
    wbyte(8'h5A, a);
    check("R4 nack when disabled", a, 0);
    check("R4 rx byte 2", rxd_rd, 8'h5A);
    sw_cmd(16'h0049);
    mstop();
    check("R9 stop event", evt_rd, 8'h01);
    check("R9 stop status", sts_rd & 8'h20, 8'h20);
    check("R9 no hold", scl_oe, 0);
    sw_cmd(16'h0049);

    // mismatch
    mstart();
    wbyte(8'hA4, a);
    check("R3 mismatch nack", a, 0);
    check("R3 no event", evt_rd, 0);
    check("R3 no irq", irq, 0);
    wbyte(8'hA0, a);
    check("R3 ignored until start", a, 0);
    mstop();
    check("R3 stop ignored", evt_rd, 0);

    // read with stall
    mstart();
    wbyte(8'hA1, a);
    check("R2 read addr ack", a, 1);
    check("R2 read dir", sts_rd & 8'h04, 8'h04);
    check("R5 held read", scl_oe, 1);
    sw_cmd(16'hC349);
    rbyte(1'b1, d);
    check("R7 tx byte", d, 8'hC3);
    check("R7 data event", evt_rd, 8'h02);
    check("R7 master ack", sts_rd & 8'h08, 8'h08);
    sw_cmd(16'h9649);
    rbyte(1'b0, d);
    check("R7 tx byte 2", d, 8'h96);
    check("R8 master nack", sts_rd & 8'h08, 0);
    sw_cmd(16'h0049);
    mbit(1'b1, s);
    check("R8 sda released", s, 1);
    mstop();
    check("R9 read stop", evt_rd, 8'h01);
    sw_cmd(16'h0049);

    // own address zero disables
    sw_own(8'h00);
    mstart();
    wbyte(8'h00, a);
    check("R3 disabled nack", a, 0);
    check("R3 disabled no event", evt_rd, 0);
    mstop();
    sw_own(8'hA0);

    // no stall, masked
    sw_cmd(16'h7758);
    mstart();
    wbyte(8'hA1, a);
    check("R10 ack", a, 1);
    check("R10 no hold", scl_oe, 0);
    check("R6 masked event", evt_rd, 8'h01);
    check("R6 masked irq", irq, 0);
    rbyte(1'b0, d);
    check("R10 last cmd byte", d, 8'h77);
    check("R10 events", evt_rd, 8'h03);
    mstop();
    check("R9 stop flag", sts_rd & 8'h20, 8'h20);
    sw_cmd(16'h0008);
    check("R6 unmasked irq", irq, 1);
    sw_cmd(16'h0048);
    check("R6 cleared all", evt_rd, 0);
    check("R6 irq low", irq, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule